// File: doc/BRIEF.md
# Range Select Decoder with Abort Target

This block sits on the address channel of a four-phase, split-transfer bus. It watches each address cycle and decodes the pushed address against a parameterised table of address windows, one window per real target. It then raises a single registered select line toward the target that owns the address. The select is timed by a return-to-zero interlock: it is raised only while the channel request is high and the acknowledge is low, and it is dropped once the acknowledge is seen high.

An address that falls inside no window is steered to a target built into the block. This target acknowledges the address cycle itself. It then runs the data cycle the initiator expects: for a read it pushes all-zero data, and for a write it takes the data and discards it. Last, it runs a response cycle that carries the originating tag, the colour and a non-zero abort code. The handler serves one abort at a time. A further unmapped address waits with its select held until the handler is free again.

Top module: `abort_select_decoder`

## Requirements
- R1: One clock edge after the address request is seen high with the acknowledge low, the select of the matching target is high. Target i owns addresses from `RANGE_LO[i]` through `RANGE_HI[i]` inclusive, and where windows overlap the lowest index wins. With the defaults, bit 0 owns 0x0000–0x0FFF, bit 1 owns 0x1000–0x1FFF, bit 2 owns 0x2000–0x3FFF and bit 3 owns 0x4000–0x47FF.
- R2: At most one select is high at any time, and an address outside every window raises no external select.
- R3: A high select is lowered on the clock edge after the address acknowledge is high.
- R4: No select is raised while the address acknowledge is still high from an earlier cycle. The decode waits until the acknowledge has fallen.
- R5: For an unmapped address, the block raises the address acknowledge one edge after its internal select. It holds the acknowledge until both the request and the internal select are low, and then drops it.
- R6: After its address cycle, the abort target raises the data request with the latched tag, colour and direction, and with all-zero read data. It holds the request until the data acknowledge is high, then lowers it and waits for the acknowledge to fall.
- R7: After the data cycle, the abort target raises the response request with the latched tag and colour and response code `ABORT_CODE` (default 2'b10, never zero). The request is held until the response acknowledge is high. The code reads zero whenever no response request is active.
- R8: While the abort target is busy, a further unmapped address gets no acknowledge and no external select. It is served, with its own tag and direction, once the earlier abort has finished its response cycle.
- R9: During reset, all selects, the address acknowledge, and the data and response requests are low, and the response code is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| a_req | input | 1 | Address channel request |
| a_addr | input | AW | Pushed address |
| a_tag | input | TW | Pushed initiator tag |
| a_col | input | CW | Pushed colour |
| a_rd | input | 1 | Pushed direction, 1 = read |
| tgt_ack | input | NT | Address acknowledge from each real target |
| a_sel | output | NT | One-hot select toward the real targets |
| a_ack | output | 1 | Combined address acknowledge |
| d_req | output | 1 | Data request from the abort target |
| d_tag | output | TW | Data cycle tag |
| d_col | output | CW | Data cycle colour |
| d_rd | output | 1 | Data cycle direction |
| d_rdata | output | DW | Read data pushed by the abort target (all zero) |
| d_ack | input | 1 | Data acknowledge from the initiator |
| r_req | output | 1 | Response request from the abort target |
| r_tag | output | TW | Response tag |
| r_col | output | CW | Response colour |
| r_code | output | RW | Response code |
| r_ack | input | 1 | Response acknowledge from the initiator |

## Verification
A wrong decode or a stale select shows on `a_sel` at the first negative edge after the request edge, as a wrong or second bit. A select register that fails to clear shows one edge after the acknowledge. A handler stuck in the wrong phase shows within a few cycles: either `a_ack` never falls, or the data or response request never appears. A lost latch of the pushed fields shows as a wrong tag, colour or direction on the later data and response cycles, most visibly when a second abort is queued behind the first.

// File: rtl/abort_select_decoder.sv
module abort_select_decoder #(
  parameter int NT = 4,
  parameter int AW = 16,
  parameter int TW = 2,
  parameter int CW = 2,
  parameter int DW = 32,
  parameter int RW = 2,
  parameter logic [RW-1:0] ABORT_CODE = 2'b10,
  parameter logic [NT*AW-1:0] RANGE_LO = 64'h4000_2000_1000_0000,
  parameter logic [NT*AW-1:0] RANGE_HI = 64'h47FF_3FFF_1FFF_0FFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_req,
  input  logic [AW-1:0] a_addr,
  input  logic [TW-1:0] a_tag,
  input  logic [CW-1:0] a_col,
  input  logic          a_rd,
  input  logic [NT-1:0] tgt_ack,
  output logic [NT-1:0] a_sel,
  output logic          a_ack,
  output logic          d_req,
  output logic [TW-1:0] d_tag,
  output logic [CW-1:0] d_col,
  output logic          d_rd,
  output logic [DW-1:0] d_rdata,
  input  logic          d_ack,
  output logic          r_req,
  output logic [TW-1:0] r_tag,
  output logic [CW-1:0] r_col,
  output logic [RW-1:0] r_code,
  input  logic          r_ack
);

  typedef enum logic [2:0] {H_IDLE, H_ADDR, H_DATA, H_DRTZ, H_RESP, H_RRTZ} hst_t;

  hst_t          st;
  logic [NT:0]   hit, sel_q;
  logic          found, ab_sel, ab_ack;
  logic [TW-1:0] tag_q;
  logic [CW-1:0] col_q;
  logic          rd_q;

  always_comb begin
    hit   = '0;
    found = 1'b0;
    for (int i = 0; i < NT; i++) begin
      if (!found && a_addr >= RANGE_LO[i*AW +: AW] && a_addr <= RANGE_HI[i*AW +: AW]) begin
        hit[i] = 1'b1;
        found  = 1'b1;
      end
    end
    if (!found) hit[NT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       sel_q <= '0;
    else if (a_ack)                   sel_q <= '0;
    else if (a_req && sel_q == '0)    sel_q <= hit;
  end

  assign a_sel  = sel_q[NT-1:0];
  assign ab_sel = sel_q[NT];
  assign ab_ack = (st == H_ADDR);
  assign a_ack  = (|tgt_ack) | ab_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= H_IDLE;
      tag_q <= '0;
      col_q <= '0;
      rd_q  <= 1'b0;
    end else begin
      case (st)
        H_IDLE: if (ab_sel) begin
          st    <= H_ADDR;
          tag_q <= a_tag;
          col_q <= a_col;
          rd_q  <= a_rd;
        end
        H_ADDR: if (!a_req && !ab_sel) st <= H_DATA;
        H_DATA: if (d_ack)  st <= H_DRTZ;
        H_DRTZ: if (!d_ack) st <= H_RESP;
        H_RESP: if (r_ack)  st <= H_RRTZ;
        H_RRTZ: if (!r_ack) st <= H_IDLE;
        default: st <= H_IDLE;
      endcase
    end
  end

  assign d_req   = (st == H_DATA);
  assign d_tag   = tag_q;
  assign d_col   = col_q;
  assign d_rd    = rd_q;
  assign d_rdata = '0;
  assign r_req   = (st == H_RESP);
  assign r_tag   = tag_q;
  assign r_col   = col_q;
  assign r_code  = r_req ? ABORT_CODE : '0;

  // R2
  onehot_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_q));

  // R1
  sel_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|sel_q) |-> $past(a_req) && !$past(a_ack));

  // R3
  sel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|sel_q && a_ack) |=> sel_q == '0);

  // R5
  abort_ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_ack && (a_req || ab_sel)) |=> ab_ack);

  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (d_req && !d_ack) |=> d_req && $stable(d_tag) && $stable(d_col));

  // R7
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_req && !r_ack) |=> r_req && $stable(r_tag) && $stable(r_col));

endmodule

// File: tb/test_abort_select_decoder.sv
`timescale 1ns/1ps
module test_abort_select_decoder;
  logic        clk = 0, rst_n = 0;
  logic        a_req = 0, a_rd = 0, d_ack = 0, r_ack = 0;
  logic [15:0] a_addr = '0;
  logic [1:0]  a_tag = '0, a_col = '0;
  logic [3:0]  tgt_ack = '0;
  logic [3:0]  a_sel;
  logic        a_ack, d_req, d_rd, r_req;
  logic [1:0]  d_tag, d_col, r_tag, r_col, r_code;
  logic [31:0] d_rdata;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  abort_select_decoder i_abort_select_decoder (.*);

  localparam logic [19:0] VEC [12] = '{
    20'h0000_1, 20'h0FFF_1, 20'h1000_2, 20'h1FFF_2, 20'h2000_4, 20'h3000_4,
    20'h3FFF_4, 20'h4000_8, 20'h47FF_8, 20'h4800_0, 20'hFFFF_0, 20'h8123_0};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic run_mapped(input logic [15:0] addr, input logic [3:0] exp);
    a_addr = addr; a_req = 1;
    step();
    chk(a_sel == exp, "R1 decode", a_sel, exp);
    chk(a_ack == 0, "R1 ack low", a_ack, 0);
    tgt_ack = exp;
    step();
    chk(a_sel == 0, "R3 select drop", a_sel, 0);
    a_req = 0;
    @(negedge clk); tgt_ack = 0;
    @(negedge clk);
  endtask

  task automatic finish_abort(input logic [1:0] tg, input logic [1:0] cl, input logic rd, input string req);
    for (int k = 0; k < 20 && !d_req; k++) @(negedge clk);
    chk(d_req == 1, req, d_req, 1);
    chk(a_ack == 0, "R5 ack dropped", a_ack, 0);
    chk(d_tag == tg && d_col == cl && d_rd == rd, req, {d_tag, d_col, d_rd}, {tg, cl, rd});
    chk(d_rdata == 0, "R6 zero data", d_rdata, 0);
    step(); step();
    chk(d_req == 1, "R6 data held", d_req, 1);
    d_ack = 1;
    for (int k = 0; k < 20 && d_req; k++) @(negedge clk);
    d_ack = 0;
    for (int k = 0; k < 20 && !r_req; k++) @(negedge clk);
    chk(r_req && r_tag == tg && r_col == cl, "R7 response fields", {r_req, r_tag, r_col}, {1'b1, tg, cl});
    chk(r_code == 2'b10, "R7 abort code", r_code, 2'b10);
    r_ack = 1;
    for (int k = 0; k < 20 && r_req; k++) @(negedge clk);
    chk(r_code == 0, "R7 code idle", r_code, 0);
    r_ack = 0;
    step();
  endtask

  task automatic run_abort(input logic [15:0] addr, input logic [1:0] tg, input logic [1:0] cl, input logic rd);
    a_addr = addr; a_tag = tg; a_col = cl; a_rd = rd; a_req = 1;
    step();
    chk(a_sel == 0 && a_ack == 0, "R2 no external select", {a_sel, a_ack}, 0);
    step();
    chk(a_ack == 1, "R5 abort ack", a_ack, 1);
    a_req = 0;
    finish_abort(tg, cl, rd, "R6 data fields");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(a_sel == 0 && a_ack == 0 && d_req == 0 && r_req == 0 && r_code == 0, "R9 reset",
        {a_sel, a_ack, d_req, r_req, r_code}, 0);
    rst_n = 1;
    step();
    chk(a_sel == 0 && a_ack == 0, "R9 after reset", {a_sel, a_ack}, 0);

    for (int v = 0; v < 12; v++) begin
      if (VEC[v][3:0] == 0) run_abort(VEC[v][19:4], v[1:0], ~v[1:0], v[0]);
      else                  run_mapped(VEC[v][19:4], VEC[v][3:0]);
    end

    // R4: acknowledge from previous cycle still high
    a_addr = 16'h1000; a_req = 1;
    step();
    tgt_ack = 4'b0010;
    step();
    a_req = 0;
    @(negedge clk);
    a_addr = 16'h2000; a_req = 1;
    step(); step();
    chk(a_sel == 0, "R4 wait for ack low", a_sel, 0);
    tgt_ack = 0;
    step();
    chk(a_sel == 4'b0100, "R4 select after ack low", a_sel, 4'b0100);
    tgt_ack = 4'b0100;
    step();
    a_req = 0;
    @(negedge clk); tgt_ack = 0;
    @(negedge clk);

    // R8: second abort queued behind first
    a_addr = 16'h9000; a_tag = 2'd1; a_col = 2'd2; a_rd = 1; a_req = 1;
    step(); step();
    a_req = 0;
    for (int k = 0; k < 20 && !d_req; k++) @(negedge clk);
    a_addr = 16'hA000; a_tag = 2'd3; a_col = 2'd1; a_rd = 0; a_req = 1;
    step(); step(); step();
    chk(a_ack == 0 && a_sel == 0, "R8 busy no ack", {a_sel, a_ack}, 0);
    chk(d_tag == 2'd1, "R8 first tag kept", d_tag, 1);
    finish_abort(2'd1, 2'd2, 1'b1, "R8 first abort");
    for (int k = 0; k < 20 && !a_ack; k++) @(negedge clk);
    chk(a_ack == 1, "R8 second served", a_ack, 1);
    a_req = 0;
    finish_abort(2'd3, 2'd1, 1'b0, "R8 second abort");

    // R9: reset in mid-abort
    a_addr = 16'hC000; a_req = 1;
    step(); step();
    a_req = 0;
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk(a_ack == 0 && d_req == 0 && r_req == 0 && a_sel == 0, "R9 reset mid-abort",
        {a_sel, a_ack, d_req, r_req}, 0);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule